// File: doc/BRIEF.md
# ATM Transmit Cell Engine

This block turns the cells held in a byte-wide transmit FIFO into a continuous stream of 53-byte cells for a downstream transmission framer. The framer asks for one byte per cycle through a clock enable. At every cell boundary the engine picks a source: a host-loaded maintenance cell that is waiting, then the next complete user cell in the FIFO, and otherwise an idle cell built from template registers. It can fill in the header check byte, scramble the 48 payload bytes, replace the flow-control nibble of user cells with a value shifted in over a serial pin, and check a marker byte placed by the ATM layer in the header check position of every arriving user cell.

The host sets the block up through a byte-wide write port. The port holds the control bits, the integrity marker, the idle template and a 54-byte maintenance buffer, and it carries two self-clearing commands. The maintenance busy flag, the sticky integrity error and the error counter are brought out as status pins.

Top module: `atm_tx_cell_engine`

## Requirements
- R1: While reset is held, out_byte is 0x00 and out_soc, rd_en, maint_busy, integ_err and integ_err_cnt are all zero. After reset the control register (address 0x00) reads hec_en=bit0=1, scr_en=bit1=0, gfc_en=bit2=0, chk_en=bit3=1.
- R2: out_byte and out_soc change only on a clock edge where out_en is high. Cells are exactly 53 bytes long and follow each other with no gap. out_soc is high only while byte 0 of a cell is presented.
- R3: With hec_en set, byte 4 of every cell (user, idle or maintenance) equals CRC-8 over the four emitted header bytes, XORed with 0x55. The CRC uses generator x^8+x^2+x+1, starts from zero and takes each byte MSB first. With hec_en clear, byte 4 is passed through from the cell source.
- R4: With scr_en set, payload bytes 5..52 are scrambled MSB first as out = in XOR (the output bit 43 positions earlier), using a 43-bit history that starts at zero and advances only on payload bytes. The header bytes are never scrambled. With scr_en clear, the payload passes through unchanged and the history holds.
- R5: At a cell boundary with no maintenance cell pending and cell_ready low, an idle cell is sent. Its payload bytes take the fill register (address 0x09, reset 0x6A).
- R6: A user cell is taken at a boundary where cell_ready is high and no maintenance cell is pending. rd_en is high, in the same cycle as out_en, for each of its 53 bytes, and rd_data is emitted in order.
- R7: Idle header bytes 0..4 come from addresses 0x04..0x08 (reset 00 00 00 01 52). A host write changes every idle cell that starts afterwards.
- R8: Writing bit0=1 to the command address 0x01 queues the maintenance cell. At the next cell boundary it is sent ahead of any waiting user cell, as buffer bytes 0..52 (addresses 0x40+k). Buffer byte 53 is never emitted.
- R9: maint_busy rises on the edge of the send command. It falls on the edge that emits byte 52 of the maintenance cell, unless a further send is queued.
- R10: With chk_en set, byte 4 of each arriving user cell is compared with the marker register (address 0x02, reset 0x5A). A mismatch sets integ_err and increments integ_err_cnt, and the cell is still transmitted. Idle and maintenance cells are never checked, and nothing is checked when chk_en is clear.
- R11: integ_err_cnt is CNT_W bits wide (default 16) and saturates at all ones.
- R12: Writing bit1=1 to address 0x01 clears integ_err and integ_err_cnt.
- R13: Each cycle with gfc_shift high shifts gfc_bit into a 4-bit register, entering at the LSB. With gfc_en set, that value replaces bits 7:4 of byte 0 of user cells only, and the header check covers the replaced nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_ready | input | 1 | FIFO holds at least one complete user cell |
| rd_en | output | 1 | Consumes rd_data this cycle |
| rd_data | input | 8 | Show-ahead FIFO head byte |
| out_en | input | 1 | Framer takes the next byte at this edge |
| out_byte | output | 8 | Outbound cell byte |
| out_soc | output | 1 | Start of cell, high on header byte 0 |
| gfc_shift | input | 1 | Serial flow-control shift strobe |
| gfc_bit | input | 1 | Serial flow-control data |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Host register address |
| reg_wdata | input | 8 | Host write data |
| maint_busy | output | 1 | Maintenance cell queued or in flight |
| integ_err | output | 1 | Sticky integrity mismatch |
| integ_err_cnt | output | CNT_W | Saturating mismatch count |

## Verification
rd_en is combinational: it depends on the current byte position, the pending flag and cell_ready, and is due in the same cycle as out_en. The bench therefore samples it shortly before the rising edge. The outbound byte, out_soc, maint_busy and the integrity status all update on the edge that consumes the byte, so they are compared one nanosecond after that edge. The reference model advances only on edges where out_en was driven high. Register writes and commands are issued in cycles with out_en low, so each one takes effect at a single, known edge.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 5;
    localparam int HEC_POS    = 4;
    localparam int MBUF_BYTES = 54;
    localparam logic [7:0] HEC_COSET = 8'h55;

    localparam int A_CTRL    = 0;
    localparam int A_CMD     = 1;
    localparam int A_PATTERN = 2;
    localparam int A_IDLE0   = 4;
    localparam int A_FILL    = 9;
    localparam int MBUF_BASE = 64;

    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_USER  = 2'd1,
        SRC_MAINT = 2'd2
    } cell_src_e;

    typedef struct packed {
        logic chk_en;
        logic gfc_en;
        logic scr_en;
        logic hec_en;
    } tx_cfg_t;

    typedef struct packed {
        tx_cfg_t                     cfg;
        logic [7:0]                  pattern;
        logic [HDR_BYTES-1:0][7:0]   idle_hdr;
        logic [7:0]                  fill;
    } reg_state_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] c;
        c = crc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/atm_tx_regs.sv
module atm_tx_regs
    import atm_tx_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int RD_IDX_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [7:0]                wdata,
    input  logic [RD_IDX_W-1:0]       mbuf_idx,
    output tx_cfg_t                   cfg,
    output logic [7:0]                pattern,
    output logic [HDR_BYTES-1:0][7:0] idle_hdr,
    output logic [7:0]                idle_fill,
    output logic [7:0]                mbuf_data,
    output logic                      send_cmd,
    output logic                      clear_cmd
);

    localparam int MB_W = $clog2(MBUF_BYTES);

    reg_state_t r_d, r_q;
    logic [MBUF_BYTES-1:0][7:0] mbuf_d, mbuf_q;
    logic [ADDR_W:0] off;
    logic in_mbuf;

    always_comb begin
        r_d    = r_q;
        mbuf_d = mbuf_q;
        off     = {1'b0, addr} - (ADDR_W+1)'(MBUF_BASE);
        in_mbuf = (addr >= ADDR_W'(MBUF_BASE)) && (off < (ADDR_W+1)'(MBUF_BYTES));
        if (wr) begin
            if (addr == ADDR_W'(A_CTRL))    r_d.cfg = tx_cfg_t'(wdata[3:0]);
            if (addr == ADDR_W'(A_PATTERN)) r_d.pattern = wdata;
            if (addr == ADDR_W'(A_FILL))    r_d.fill = wdata;
            for (int k = 0; k < HDR_BYTES; k++) begin
                if (addr == ADDR_W'(A_IDLE0 + k)) r_d.idle_hdr[k] = wdata;
            end
            if (in_mbuf) mbuf_d[off[MB_W-1:0]] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg      <= tx_cfg_t'(4'b1001);
            r_q.pattern  <= 8'h5A;
            r_q.idle_hdr <= {8'h52, 8'h01, 8'h00, 8'h00, 8'h00};
            r_q.fill     <= 8'h6A;
            mbuf_q       <= '0;
        end else begin
            r_q    <= r_d;
            mbuf_q <= mbuf_d;
        end
    end

    assign cfg       = r_q.cfg;
    assign pattern   = r_q.pattern;
    assign idle_hdr  = r_q.idle_hdr;
    assign idle_fill = r_q.fill;
    assign mbuf_data = mbuf_q[mbuf_idx];
    assign send_cmd  = wr && (addr == ADDR_W'(A_CMD)) && wdata[0];
    assign clear_cmd = wr && (addr == ADDR_W'(A_CMD)) && wdata[1];

endmodule

// File: rtl/atm_tx_scrambler.sv
module atm_tx_scrambler #(
    parameter int TAP = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [7:0] din,
    output logic [7:0] dout
);

    logic [TAP-1:0] hist_d, hist_q;
    logic [TAP-1:0] h;
    logic [7:0]     o;

    always_comb begin
        h = hist_q;
        o = '0;
        for (int i = 7; i >= 0; i--) begin
            o[i] = din[i] ^ h[TAP-1];
            h    = {h[TAP-2:0], o[i]};
        end
        dout   = o;
        hist_d = adv ? h : hist_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

endmodule

// File: rtl/atm_tx_hec.sv
module atm_tx_hec
    import atm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       restart,
    input  logic [7:0] din,
    output logic [7:0] hec
);

    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (upd) crc_d = crc8_step(restart ? 8'h00 : crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign hec = crc_q ^ HEC_COSET;

endmodule

// File: rtl/atm_tx_gfc_port.sv
module atm_tx_gfc_port #(
    parameter int GFC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             bit_in,
    output logic [GFC_W-1:0] value
);

    logic [GFC_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift) sr_d = {sr_q[GFC_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign value = sr_q;

endmodule

// File: rtl/atm_tx_cell_engine.sv
module atm_tx_cell_engine
    import atm_tx_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int CNT_W   = 16,
    parameter int SCR_TAP = 43,
    parameter int GFC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_ready,
    output logic              rd_en,
    input  logic [7:0]        rd_data,
    input  logic              out_en,
    output logic [7:0]        out_byte,
    output logic              out_soc,
    input  logic              gfc_shift,
    input  logic              gfc_bit,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              maint_busy,
    output logic              integ_err,
    output logic [CNT_W-1:0]  integ_err_cnt
);

    localparam int IDX_W = $clog2(CELL_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
    localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HEC_POS);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        cell_src_e        src;
        logic             pend;
        logic             busy;
        logic             sticky;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       obyte;
        logic             osoc;
    } eng_state_t;

    eng_state_t s_d, s_q;

    tx_cfg_t                   cfg;
    logic [7:0]                pattern;
    logic [HDR_BYTES-1:0][7:0] idle_hdr;
    logic [7:0]                idle_fill;
    logic [7:0]                mbuf_data;
    logic                      send_cmd;
    logic                      clear_cmd;
    logic [GFC_W-1:0]          gfc_val;
    logic [7:0]                hec_byte;
    logic [7:0]                scr_byte;

    logic       at_start, in_hdr, at_hec, in_pay;
    cell_src_e  sel_src;
    logic [7:0] idle_byte, raw, emit;
    logic       chk_fail;

    atm_tx_regs #(.ADDR_W(ADDR_W), .RD_IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .mbuf_idx  (s_q.idx),
        .cfg       (cfg),
        .pattern   (pattern),
        .idle_hdr  (idle_hdr),
        .idle_fill (idle_fill),
        .mbuf_data (mbuf_data),
        .send_cmd  (send_cmd),
        .clear_cmd (clear_cmd)
    );

    atm_tx_gfc_port #(.GFC_W(GFC_W)) u_gfc (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (gfc_shift),
        .bit_in (gfc_bit),
        .value  (gfc_val)
    );

    atm_tx_hec u_hec (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (out_en && in_hdr),
        .restart (at_start),
        .din     (raw),
        .hec     (hec_byte)
    );

    atm_tx_scrambler #(.TAP(SCR_TAP)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (out_en && in_pay && cfg.scr_en),
        .din   (raw),
        .dout  (scr_byte)
    );

    // Byte path: source selection, header rewrite, check byte, scrambling.
    always_comb begin
        at_start = (s_q.idx == '0);
        in_hdr   = (s_q.idx < HEC_IDX);
        at_hec   = (s_q.idx == HEC_IDX);
        in_pay   = !in_hdr && !at_hec;

        if (at_start) sel_src = s_q.pend ? SRC_MAINT : (cell_ready ? SRC_USER : SRC_IDLE);
        else          sel_src = s_q.src;

        if (in_pay) idle_byte = idle_fill;
        else        idle_byte = idle_hdr[s_q.idx[2:0]];

        case (sel_src)
            SRC_USER:  raw = rd_data;
            SRC_MAINT: raw = mbuf_data;
            default:   raw = idle_byte;
        endcase
        if (sel_src == SRC_USER && at_start && cfg.gfc_en) raw = {gfc_val, raw[3:0]};

        if (at_hec && cfg.hec_en)      emit = hec_byte;
        else if (in_pay && cfg.scr_en) emit = scr_byte;
        else                           emit = raw;

        rd_en    = out_en && (sel_src == SRC_USER);
        chk_fail = out_en && (sel_src == SRC_USER) && at_hec && cfg.chk_en && (rd_data != pattern);
    end

    // Next state.
    always_comb begin
        s_d = s_q;
        if (out_en) begin
            s_d.idx   = (s_q.idx == LAST_IDX) ? '0 : s_q.idx + 1'b1;
            s_d.src   = sel_src;
            s_d.obyte = emit;
            s_d.osoc  = at_start;
            if (at_start && s_q.pend) s_d.pend = 1'b0;
            if (sel_src == SRC_MAINT && s_q.idx == LAST_IDX) s_d.busy = s_q.pend;
        end
        if (chk_fail) begin
            s_d.sticky = 1'b1;
            if (s_q.cnt != '1) s_d.cnt = s_q.cnt + 1'b1;
        end
        if (send_cmd) begin
            s_d.pend = 1'b1;
            s_d.busy = 1'b1;
        end
        if (clear_cmd) begin
            s_d.sticky = 1'b0;
            s_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.idx    <= '0;
            s_q.src    <= SRC_IDLE;
            s_q.pend   <= 1'b0;
            s_q.busy   <= 1'b0;
            s_q.sticky <= 1'b0;
            s_q.cnt    <= '0;
            s_q.obyte  <= '0;
            s_q.osoc   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_byte      = s_q.obyte;
    assign out_soc       = s_q.osoc;
    assign maint_busy    = s_q.busy;
    assign integ_err     = s_q.sticky;
    assign integ_err_cnt = s_q.cnt;

endmodule

// File: rtl/atm_tx_cell_engine_chk.sv
module atm_tx_cell_engine_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_en,
    input logic [7:0]       out_byte,
    input logic             out_soc,
    input logic             maint_busy,
    input logic             integ_err,
    input logic [CNT_W-1:0] integ_err_cnt
);

    localparam int SLOT_W = 6;
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      slot_q <= '0;
        else if (out_en) slot_q <= (slot_q == SLOT_W'(52)) ? '0 : slot_q + 1'b1;
    end

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> ($stable(out_byte) && $stable(out_soc)));

    // R2
    soc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> (out_soc == ($past(slot_q) == '0)));

    // R9
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(maint_busy) |-> $past(out_en));

    // R10
    sticky_with_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_err_cnt != '0) |-> integ_err);

    // R11
    count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_err_cnt == '1) |=> ((integ_err_cnt == '1) || (integ_err_cnt == '0)));

endmodule

bind atm_tx_cell_engine atm_tx_cell_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_en        (out_en),
    .out_byte      (out_byte),
    .out_soc       (out_soc),
    .maint_busy    (maint_busy),
    .integ_err     (integ_err),
    .integ_err_cnt (integ_err_cnt)
);

// File: tb/atm_tx_cell_engine_test.sv
module atm_tx_cell_engine_test;

    localparam int CNT_W = 4;
    localparam int FQ    = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             cell_ready;
    logic             rd_en;
    logic [7:0]       rd_data;
    logic             out_en;
    logic [7:0]       out_byte;
    logic             out_soc;
    logic             gfc_shift;
    logic             gfc_bit;
    logic             reg_wr;
    logic [6:0]       reg_addr;
    logic [7:0]       reg_wdata;
    logic             maint_busy;
    logic             integ_err;
    logic [CNT_W-1:0] integ_err_cnt;

    atm_tx_cell_engine #(.ADDR_W(7), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cell_ready(cell_ready), .rd_en(rd_en), .rd_data(rd_data),
        .out_en(out_en), .out_byte(out_byte), .out_soc(out_soc),
        .gfc_shift(gfc_shift), .gfc_bit(gfc_bit),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .maint_busy(maint_busy), .integ_err(integ_err), .integ_err_cnt(integ_err_cnt)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] fifo_mem [FQ];
    int fifo_wr = 0;
    int fifo_rd = 0;

    // reference model state
    int          m_idx, m_src;
    logic        m_pend, m_busy, m_sticky;
    int          m_cnt;
    logic [7:0]  m_crc;
    logic [42:0] m_scr;
    logic [3:0]  m_gfc;
    logic        c_hec, c_scr, c_gfc, c_chk;
    logic [7:0]  m_pattern, m_fill;
    logic [7:0]  m_idle [5];
    logic [7:0]  m_mbuf [54];
    logic [7:0]  last_byte;
    logic        last_soc;

    logic       nx_wr, nx_shift, nx_bit;
    logic [6:0] nx_addr;
    logic [7:0] nx_data;

    task automatic expect_eq(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_next(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
        return r;
    endfunction

    function automatic logic [7:0] scr_apply(input logic [7:0] d);
        logic [7:0] o;
        for (int i = 7; i >= 0; i--) begin
            o[i]  = d[i] ^ m_scr[42];
            m_scr = {m_scr[41:0], o[i]};
        end
        return o;
    endfunction

    task automatic push_cell(input bit good);
        for (int k = 0; k < 53; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (k == 4) b = good ? m_pattern : ~m_pattern;
            fifo_mem[fifo_wr % FQ] = b;
            fifo_wr++;
        end
    endtask

    task automatic step(input bit en);
        int   exp_src;
        logic exp_rd;
        logic [7:0] raw, b, head;
        string tag;
        @(negedge clk);
        out_en     = en;
        reg_wr     = nx_wr;
        reg_addr   = nx_addr;
        reg_wdata  = nx_data;
        gfc_shift  = nx_shift;
        gfc_bit    = nx_bit;
        cell_ready = (fifo_wr - fifo_rd) >= 53;
        head       = fifo_mem[fifo_rd % FQ];
        rd_data    = head;
        #2;
        exp_src = (m_idx == 0) ? (m_pend ? 2 : (cell_ready ? 1 : 0)) : m_src;
        exp_rd  = en && (exp_src == 1);
        expect_eq("R6", "rd_en", 32'(rd_en), 32'(exp_rd));
        @(posedge clk);
        #1;
        if (en) begin
            if (m_idx == 0) begin
                m_src = exp_src;
                if (m_pend) m_pend = 1'b0;
            end
            case (m_src)
                1:       raw = head;
                2:       raw = m_mbuf[m_idx];
                default: raw = (m_idx < 5) ? m_idle[m_idx] : m_fill;
            endcase
            tag = (m_src == 1) ? "R6" : (m_src == 2) ? "R8" : (m_idx < 5) ? "R7" : "R5";
            if (m_src == 1 && c_gfc && m_idx == 0) begin
                raw = {m_gfc, raw[3:0]};
                tag = "R13";
            end
            if (m_idx < 4) begin
                m_crc = crc_next((m_idx == 0) ? 8'h00 : m_crc, raw);
                b = raw;
            end else if (m_idx == 4) begin
                b = c_hec ? (m_crc ^ 8'h55) : raw;
                if (c_hec) tag = "R3";
                if (m_src == 1 && c_chk && head != m_pattern) begin
                    m_sticky = 1'b1;
                    if (m_cnt != (1 << CNT_W) - 1) m_cnt++;
                end
            end else begin
                b = c_scr ? scr_apply(raw) : raw;
                if (c_scr) tag = "R4";
            end
            last_byte = b;
            last_soc  = (m_idx == 0);
            if (m_src == 2 && m_idx == 52) m_busy = m_pend;
            m_idx = (m_idx == 52) ? 0 : m_idx + 1;
            if (exp_rd) fifo_rd++;
            expect_eq(tag, "out_byte", 32'(out_byte), 32'(last_byte));
        end else begin
            expect_eq("R2", "held out_byte", 32'(out_byte), 32'(last_byte));
        end
        expect_eq("R2", "out_soc", 32'(out_soc), 32'(last_soc));
        if (nx_shift) m_gfc = {m_gfc[2:0], nx_bit};
        if (nx_wr) begin
            if (nx_addr == 7'd0) {c_chk, c_gfc, c_scr, c_hec} = nx_data[3:0];
            if (nx_addr == 7'd1 && nx_data[0]) begin m_pend = 1'b1; m_busy = 1'b1; end
            if (nx_addr == 7'd1 && nx_data[1]) begin m_sticky = 1'b0; m_cnt = 0; end
            if (nx_addr == 7'd2) m_pattern = nx_data;
            if (nx_addr >= 7'd4 && nx_addr <= 7'd8) m_idle[nx_addr - 7'd4] = nx_data;
            if (nx_addr == 7'd9) m_fill = nx_data;
            if (nx_addr >= 7'd64 && nx_addr < 7'd118) m_mbuf[nx_addr - 7'd64] = nx_data;
        end
        expect_eq("R9", "maint_busy", 32'(maint_busy), 32'(m_busy));
        expect_eq("R10", "integ_err", 32'(integ_err), 32'(m_sticky));
        expect_eq("R11", "integ_err_cnt", 32'(integ_err_cnt), 32'(m_cnt));
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        nx_wr = 1'b1; nx_addr = a; nx_data = d;
        step(1'b0);
        nx_wr = 1'b0;
    endtask

    task automatic shift_gfc(input logic bv);
        nx_shift = 1'b1; nx_bit = bv;
        step(1'b0);
        nx_shift = 1'b0;
    endtask

    task automatic run(input int n, input int pct);
        for (int i = 0; i < n; i++) step(($urandom % 100) < pct);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; out_en = 1'b0; cell_ready = 1'b0; rd_data = 8'h00;
        gfc_shift = 1'b0; gfc_bit = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        nx_wr = 1'b0; nx_shift = 1'b0; nx_bit = 1'b0; nx_addr = '0; nx_data = '0;
        m_idx = 0; m_src = 0; m_pend = 0; m_busy = 0; m_sticky = 0; m_cnt = 0;
        m_crc = '0; m_scr = '0; m_gfc = '0;
        {c_chk, c_gfc, c_scr, c_hec} = 4'b1001;
        m_pattern = 8'h5A; m_fill = 8'h6A;
        m_idle[0] = 8'h00; m_idle[1] = 8'h00; m_idle[2] = 8'h00; m_idle[3] = 8'h01; m_idle[4] = 8'h52;
        for (int k = 0; k < 54; k++) m_mbuf[k] = 8'h00;
        last_byte = 8'h00; last_soc = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect_eq("R1", "out_byte", 32'(out_byte), 32'h00);
        expect_eq("R1", "out_soc", 32'(out_soc), 32'h0);
        expect_eq("R1", "rd_en", 32'(rd_en), 32'h0);
        expect_eq("R1", "maint_busy", 32'(maint_busy), 32'h0);
        expect_eq("R1", "integ_err", 32'(integ_err), 32'h0);
        expect_eq("R1", "integ_err_cnt", 32'(integ_err_cnt), 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R5 R3: idle cells with defaults (check byte of idle header is 0x52)
        run(110, 100);
        // R6 R10: user cells carrying the right marker
        push_cell(1); push_cell(1);
        run(120, 80);
        // R4 scrambling on
        wr(7'd0, 8'h0B);
        push_cell(1);
        run(150, 100);
        // R13 serial flow-control nibble 1011
        shift_gfc(1); shift_gfc(0); shift_gfc(1); shift_gfc(1);
        wr(7'd0, 8'h0D);
        push_cell(1);
        run(120, 100);
        // R8 R9 maintenance cell beats a waiting user cell
        for (int k = 0; k < 54; k++) wr(7'(64 + k), 8'(k * 3 + 1));
        push_cell(1);
        wr(7'd1, 8'h01);
        run(170, 100);
        // R3 check byte passed through with hec off; R7 new idle template
        wr(7'd0, 8'h08);
        wr(7'd4, 8'hC3); wr(7'd8, 8'h9E); wr(7'd9, 8'h11);
        push_cell(1);
        run(120, 100);
        // R10 R11 mismatches saturate the counter
        wr(7'd0, 8'h09);
        for (int c = 0; c < 17; c++) begin
            push_cell(0);
            run(53, 100);
        end
        expect_eq("R11", "saturated count", 32'(integ_err_cnt), 32'((1 << CNT_W) - 1));
        // R12 clear
        wr(7'd1, 8'h02);
        expect_eq("R12", "cleared count", 32'(integ_err_cnt), 32'h0);
        expect_eq("R12", "cleared sticky", 32'(integ_err), 32'h0);
        // R10 no check when disabled
        wr(7'd0, 8'h01);
        push_cell(0);
        run(110, 100);
        expect_eq("R10", "disabled check count", 32'(integ_err_cnt), 32'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 4 && (fifo_wr - fifo_rd) < 800) push_cell(($urandom % 4) != 0);
            else if (r < 6) shift_gfc(1'($urandom));
            else if (r == 6) wr(7'd0, 8'($urandom % 16));
            else if (r == 7) wr(7'd1, 8'($urandom % 4));
            else if (r == 8) wr(7'(4 + $urandom % 6), 8'($urandom));
            else if (r == 9) wr(7'(64 + $urandom % 54), 8'($urandom));
            else step(($urandom % 100) < 75);
        end
        run(2000, 100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule